// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the arithmetic and logic unit of a simple 32-bit integer datapath together with the small decoder that chooses its operation. A main controller supplies a 2-bit instruction class; for register-to-register instructions the 6-bit function field of the instruction word then selects the exact operation. The decoder turns these two inputs into a sparse 3-bit operation code, and the ALU applies that code to two operands.

The whole block is combinational. It yields a result word, a zero flag for branch decisions, and a carry and a signed overflow flag from its single shared adder. Address arithmetic for loads and stores uses the add class; equality branches use the subtract class and test the zero flag.

Top module: `alu_two_level`

## Requirements
- R1: Class `00` gives operation code `010` (add) whatever the function field holds.
- R2: Class `01` gives operation code `110` (subtract) whatever the function field holds.
- R3: Class `10` decodes the function field: `100000` gives `010` (add), `100010` gives `110` (subtract), `100100` gives `000` (AND), `100101` gives `001` (OR), `101010` gives `111` (set-less-than).
- R4: Class `10` with any other function value, and class `11` with any function value, give the unused code `011`; the result is zero, carry and overflow are 0.
- R5: Code `000` yields the bitwise AND of the operands, code `001` their bitwise OR; both drive carry and overflow to 0.
- R6: Code `010` yields a+b modulo 2^32; carry is bit 32 of the unsigned sum; overflow is 1 when two operands of equal sign give a result of the other sign.
- R7: Code `110` yields a-b modulo 2^32; carry is 1 exactly when a >= b as unsigned numbers (no borrow); overflow is 1 when operands of differing sign give a result whose sign differs from a.
- R8: Code `111` yields 1 when a < b as signed two's complement numbers and 0 otherwise, correct even when a-b overflows; carry and overflow report the subtraction a-b as in R7.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class | input | 2 | Instruction class from the main controller |
| funct | input | 6 | Function field of the instruction word |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | output | 3 | Decoded ALU operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Adder carry (no-borrow for subtraction) |
| overflow | output | 1 | Signed overflow of the adder |

## Verification
Each class is driven with function values that belong to other classes, which tells a decoder that truly ignores the field from one that leaks it. Add and subtract are tried on operands that wrap unsigned, wrap signed and land exactly on zero, separating the carry, overflow and zero flags from one another. Set-less-than is tried with a negative-versus-positive pair, equal operands and both overflowing orderings, which separates a true signed compare from an unsigned one and from a plain sign-of-difference test. A one-hot sweep of the result through OR checks that every result bit feeds the zero flag.

// File: rtl/alu_two_level.sv
module alu_two_level #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       alu_class,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [2:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  localparam logic [2:0] OP_AND  = 3'b000;
  localparam logic [2:0] OP_OR   = 3'b001;
  localparam logic [2:0] OP_ADD  = 3'b010;
  localparam logic [2:0] OP_NONE = 3'b011;
  localparam logic [2:0] OP_SUB  = 3'b110;
  localparam logic [2:0] OP_SLT  = 3'b111;

  always_comb begin
    unique case (alu_class)
      2'b00: op_code = OP_ADD;
      2'b01: op_code = OP_SUB;
      2'b10: begin
        case (funct)
          6'b100000: op_code = OP_ADD;
          6'b100010: op_code = OP_SUB;
          6'b100100: op_code = OP_AND;
          6'b100101: op_code = OP_OR;
          6'b101010: op_code = OP_SLT;
          default:   op_code = OP_NONE;
        endcase
      end
      default: op_code = OP_NONE;
    endcase
  end

  logic             invert_b;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_ext;
  logic             add_ovf;
  logic             is_arith;

  assign invert_b = op_code[2];
  assign b_eff    = invert_b ? ~op_b : op_b;
  assign sum_ext  = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, invert_b};
  assign add_ovf  = (op_a[WIDTH-1] == b_eff[WIDTH-1]) && (sum_ext[WIDTH-1] != op_a[WIDTH-1]);
  assign is_arith = (op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_SLT);

  always_comb begin
    case (op_code)
      OP_AND:  result = op_a & op_b;
      OP_OR:   result = op_a | op_b;
      OP_ADD,
      OP_SUB:  result = sum_ext[WIDTH-1:0];
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, sum_ext[WIDTH-1] ^ add_ovf};
      default: result = '0;
    endcase
  end

  assign zero      = ~|result;
  assign carry_out = is_arith & sum_ext[WIDTH];
  assign overflow  = is_arith & add_ovf;

  always_comb begin
    if (!$isunknown({alu_class, funct, op_a, op_b})) begin
      assert_class_add_R1: assert (alu_class != 2'b00 || op_code == OP_ADD)
        else $error("R1 class 00 did not decode to add");
      assert_class_sub_R2: assert (alu_class != 2'b01 || op_code == OP_SUB)
        else $error("R2 class 01 did not decode to subtract");
      assert_funct_slt_R3: assert (!(alu_class == 2'b10 && funct == 6'b101010) || op_code == OP_SLT)
        else $error("R3 slt function did not decode");
      assert_unused_quiet_R4: assert (op_code != OP_NONE || (result == '0 && !carry_out && !overflow))
        else $error("R4 unused code produced activity");
      assert_logic_no_flags_R5: assert (op_code[2:1] != 2'b00 || (!carry_out && !overflow))
        else $error("R5 logic op raised arithmetic flags");
      assert_slt_single_bit_R8: assert (op_code != OP_SLT || result[WIDTH-1:1] == '0)
        else $error("R8 slt result wider than one bit");
      assert_zero_flag_R9: assert (zero == (result == '0))
        else $error("R9 zero flag mismatch");
    end
  end
endmodule

// File: tb/test_alu_two_level.sv
`timescale 1ns/1ps
module test_alu_two_level;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  alu_class;
  logic [5:0]  funct;
  logic [31:0] op_a, op_b;
  logic [2:0]  op_code;
  logic [31:0] result;
  logic        zero, carry_out, overflow;

  alu_two_level i_alu_two_level (
    .alu_class(alu_class), .funct(funct), .op_a(op_a), .op_b(op_b),
    .op_code(op_code), .result(result), .zero(zero),
    .carry_out(carry_out), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {class, funct, a, b, expected result, zero, carry, overflow, expected op}
  localparam int NV = 17;
  localparam logic [109:0] VEC [NV] = '{
    {2'b00, 6'b000000, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 3'b000, 3'b010},
    {2'b00, 6'b100010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 3'b110, 3'b010},
    {2'b01, 6'b100100, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 3'b110, 3'b110},
    {2'b01, 6'b000000, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 3'b000, 3'b110},
    {2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 3'b001, 3'b010},
    {2'b10, 6'b100010, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 3'b011, 3'b110},
    {2'b10, 6'b100100, 32'hF0F0_1234, 32'hFF00_FF00, 32'hF000_1200, 3'b000, 3'b000},
    {2'b10, 6'b100101, 32'hF0F0_1234, 32'h0F00_00FF, 32'hFFF0_12FF, 3'b000, 3'b001},
    {2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 3'b100, 3'b000},
    {2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 3'b010, 3'b111},
    {2'b10, 6'b101010, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 3'b100, 3'b111},
    {2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 3'b011, 3'b111},
    {2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 3'b101, 3'b111},
    {2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 3'b110, 3'b111},
    {2'b10, 6'b000000, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 3'b100, 3'b011},
    {2'b11, 6'b100000, 32'h0000_0003, 32'h0000_0004, 32'h0000_0000, 3'b100, 3'b011},
    {2'b10, 6'b100101, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'b100, 3'b001}
  };

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'b000, 3'b001: return "R5";
      3'b010:         return "R6";
      3'b110:         return "R7";
      3'b111:         return "R8";
      default:        return "R4";
    endcase
  endfunction

  function automatic string dec_req(input logic [1:0] cls);
    case (cls)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    alu_class = c; funct = f; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  initial begin
    alu_class = 2'b00; funct = '0; op_a = '0; op_b = '0;
    @(negedge clk);
    check("R9", "idle result", result, 32'h0);
    check("R9", "idle zero", {31'h0, zero}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [109:0] v;
      v = VEC[i];
      apply(v[109:108], v[107:102], v[101:70], v[69:38]);
      check(dec_req(v[109:108]), "op code", {29'h0, op_code}, {29'h0, v[2:0]});
      check(op_req(v[2:0]), "result", result, v[37:6]);
      check("R9", "zero", {31'h0, zero}, {31'h0, v[5]});
      check(op_req(v[2:0]), "carry", {31'h0, carry_out}, {31'h0, v[4]});
      check(op_req(v[2:0]), "overflow", {31'h0, overflow}, {31'h0, v[3]});
    end

    // R1, R2: function field ignored outside class 10
    for (int f = 0; f < 64; f += 5) begin
      apply(2'b00, 6'(f), 32'h1, 32'h2);
      check("R1", "class 00 sweep op", {29'h0, op_code}, 32'h2);
      check("R1", "class 00 sweep result", result, 32'h3);
      apply(2'b01, 6'(f), 32'h1, 32'h2);
      check("R2", "class 01 sweep op", {29'h0, op_code}, 32'h6);
      check("R2", "class 01 sweep result", result, 32'hFFFF_FFFF);
    end

    // R9: each single result bit clears the zero flag
    for (int i = 0; i < 32; i++) begin
      apply(2'b10, 6'b100101, 32'h1 << i, 32'h0);
      check("R9", "one-hot zero", {31'h0, zero}, 32'h0);
    end

    // R6: full carry and overflow together
    apply(2'b10, 6'b100000, 32'h8000_0000, 32'h8000_0000);
    check("R6", "min+min result", result, 32'h0);
    check("R6", "min+min carry", {31'h0, carry_out}, 32'h1);
    check("R6", "min+min overflow", {31'h0, overflow}, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule